// File: doc/BRIEF.md
# DDR2 Extended Mode Register Tracker

This block watches the command pins of a DDR2-style SDRAM on the device side. It recognises loads of the first extended mode register and turns the sampled address bits into decoded configuration outputs. These outputs are the DLL request, output drive strength, termination selection, additive latency, off-chip driver calibration mode, complementary strobe disable and output-buffer shutdown. A load is accepted only when every bank is precharged and CKE was already high. Loads that break this rule, or that carry a reserved code, leave the stored contents untouched and raise a one-cycle error pulse.

The block also checks command timing around the register. A command other than NOP that arrives too soon after an accepted load raises a spacing flag. A lock-interval state machine follows the internal DLL through its four states. DLL_OFF moves to DLL_LOCKING on an accepted load with A0=0. DLL_LOCKING moves to DLL_READY when the lock interval expires, and moves back to DLL_OFF on a load with A0=1. DLL_READY moves to DLL_OFF on a load with A0=1. From any of these three states, a self-refresh entry moves to DLL_SREF. When self refresh ends, DLL_SREF moves to DLL_LOCKING if the register asks for the DLL, and to DLL_OFF otherwise. A read that arrives while the DLL is in DLL_LOCKING is flagged.

A second state machine holds the register status. CFG_BLANK covers the time before any accepted load. CFG_VALID holds a normal setting. CFG_CAL means calibration default mode was entered and has not yet been left. The transitions are: CFG_BLANK to CFG_VALID or CFG_CAL on the first accepted load, CFG_VALID to CFG_CAL on an accepted load with mode 111, and CFG_CAL to CFG_VALID on an accepted load with mode 000.

Top module: `ddr2_xmr_tracker`

## Requirements
- R1: A register load is decoded on a rising clock edge where cke=1, cs_n=ras_n=cas_n=we_n=0, ba[1]=0 and ba[0]=1. The fields are stored at that edge and appear on the outputs right after it.
- R2: A load is accepted only if banks_idle=1 and cke was also 1 at the previous edge. Otherwise wr_err pulses high for one cycle after the edge, and every configuration output keeps its value.
- R3: After reset, cfg_written=0, all configuration outputs are 0, dll_active=0, dll_ready=0 and all flags are 0. cfg_written goes to 1 on the first accepted load and stays at 1.
- R4: Field mapping. dll_en_cfg = !A0 (only once cfg_written=1). half_drive = A1. odt_sel = {A6,A2}, where 00 means off, 01 means 75 ohm, 10 means 150 ohm and 11 means 50 ohm. dqsn_off = A10. q_off = A12.
- R5: add_lat takes A5..A3 as a value from 0 to 6.
- R6: If TMRD (default 2) is larger than 1, a command other than NOP or deselect that arrives 1 to TMRD-1 edges after an accepted load pulses mrd_viol for one cycle. Deselect (cs_n=1) never counts.
- R7: An accepted load with A0=0 while the DLL is off starts the lock interval. A read (cs_n=0, ras_n=1, cas_n=0, we_n=1) at edges 1 to LOCK_CYC-1 after the start (default 200) pulses early_rd. dll_ready rises at edge LOCK_CYC-1, and a read at edge LOCK_CYC is not flagged. While the DLL is off, reads are not flagged.
- R8: An accepted load with A11=1 or ba[2]=1 pulses rsvd_warn, and the load is still applied.
- R9: cal_pending goes to 1 when a load with A9..A7=111 is accepted. It returns to 0 only when a load with A9..A7=000 is accepted.
- R10: When A9..A7=100 (adjust), add_lat keeps its stored value, and the A5..A3 bits of that load are ignored.
- R11: A load with A5..A3=111 (outside adjust), or with A9..A7 equal to 011, 101 or 110, pulses cfg_err and changes nothing.
- R12: A refresh pattern (cs_n=ras_n=cas_n=0, we_n=1) sampled with cke=0 after cke=1 enters self refresh and turns dll_active off. The first edge with cke=1 leaves self refresh and restarts the full lock interval if dll_en_cfg=1. An accepted load with A0=1 turns the DLL off, and a load with A0=0 while the DLL is already on does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 13 | Address pins A12..A0 |
| banks_idle | input | 1 | High when every bank is precharged |
| cfg_written | output | 1 | Register has been loaded at least once |
| dll_en_cfg | output | 1 | Stored DLL request (1 = enable) |
| half_drive | output | 1 | Reduced output drive strength |
| odt_sel | output | 2 | Termination selection code |
| add_lat | output | 3 | Additive latency in cycles |
| ocd_mode | output | 3 | Stored calibration mode code |
| dqsn_off | output | 1 | Complementary strobe disabled |
| q_off | output | 1 | Data and strobe output buffers off |
| cal_pending | output | 1 | Calibration default entered, exit still due |
| dll_active | output | 1 | Internal DLL running (locking or locked) |
| dll_ready | output | 1 | Lock interval complete |
| wr_err | output | 1 | Pulse: load refused by precondition |
| cfg_err | output | 1 | Pulse: load refused by reserved code |
| rsvd_warn | output | 1 | Pulse: reserved bit set in an accepted load |
| mrd_viol | output | 1 | Pulse: command too soon after a load |
| early_rd | output | 1 | Pulse: read before lock completes |

## Verification
A wrong status state shows up on cfg_written or cal_pending right after the edge of the next load. Wrong field latching shows up in the same cycle on the decoded outputs. A lock counter that is off by one cycle moves the last flagged read and the rise of dll_ready by one edge, so the bench probes edges LOCK_CYC-1 and LOCK_CYC. A self-refresh exit that does not reload the counter can only be seen later. It shows as a missing early_rd on a read more than halfway through a fresh interval, so the bench enters self refresh part-way through a lock and reads 150 cycles after the exit.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_EMR1,
        CMD_READ,
        CMD_SRE,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        CFG_BLANK,
        CFG_VALID,
        CFG_CAL
    } cfg_state_e;

    typedef enum logic [1:0] {
        DLL_OFF,
        DLL_LOCKING,
        DLL_READY,
        DLL_SREF
    } dll_state_e;

    localparam logic [2:0] OCD_EXIT = 3'b000;
    localparam logic [2:0] OCD_DRV1 = 3'b001;
    localparam logic [2:0] OCD_DRV0 = 3'b010;
    localparam logic [2:0] OCD_ADJ  = 3'b100;
    localparam logic [2:0] OCD_DFLT = 3'b111;
    localparam logic [2:0] AL_RSVD  = 3'b111;

    typedef struct packed {
        logic       dll_off;
        logic       half_drive;
        logic [1:0] odt;
        logic [2:0] al;
        logic [2:0] ocd;
        logic       dqsn_dis;
        logic       q_off;
    } cfg_t;

    function automatic logic ocd_known(input logic [2:0] code);
        return (code == OCD_EXIT) || (code == OCD_DRV1) || (code == OCD_DRV0) ||
               (code == OCD_ADJ)  || (code == OCD_DFLT);
    endfunction

endpackage

// File: rtl/xmr_cmd_decode.sv
module xmr_cmd_decode
    import xmr_pkg::*;
(
    input  logic       cke,
    input  logic       cke_q,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba_lo,
    output cmd_e       cmd
);

    // R1 load decode, R7 read decode, R12 self-refresh entry decode
    always_comb begin
        cmd = CMD_NOP;
        if (cke_q && !cke) begin
            if (!cs_n && !ras_n && !cas_n && we_n)
                cmd = CMD_SRE;
        end else if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b000:  cmd = (ba_lo == 2'b01) ? CMD_EMR1 : CMD_OTHER;
                3'b101:  cmd = CMD_READ;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/xmr_cfg_ctrl.sv
module xmr_cfg_ctrl
    import xmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_cmd,
    input  logic        pre_ok,
    input  logic [12:0] addr,
    input  logic        ba_hi,
    output cfg_t        cfg,
    output logic        written,
    output logic        cal_pending,
    output logic        accept,
    output logic        wr_err,
    output logic        cfg_err,
    output logic        rsvd_warn
);

    cfg_state_e state_q, state_d;
    cfg_t       cfg_d;
    logic [2:0] new_al;
    logic [2:0] new_ocd;
    logic       al_bad;
    logic       ocd_bad;

    assign new_al  = addr[5:3];
    assign new_ocd = addr[9:7];
    assign al_bad  = (new_ocd != OCD_ADJ) && (new_al == AL_RSVD);   // R11
    assign ocd_bad = !ocd_known(new_ocd);                            // R11
    assign accept  = load_cmd && pre_ok && !al_bad && !ocd_bad;      // R2

    // R4 R5 R10 field capture
    always_comb begin
        cfg_d.dll_off    = addr[0];
        cfg_d.half_drive = addr[1];
        cfg_d.odt        = {addr[6], addr[2]};
        cfg_d.al         = (new_ocd == OCD_ADJ) ? cfg.al : new_al;
        cfg_d.ocd        = new_ocd;
        cfg_d.dqsn_dis   = addr[10];
        cfg_d.q_off      = addr[12];
    end

    // R3 R9 status transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_BLANK: if (accept) state_d = (new_ocd == OCD_DFLT) ? CFG_CAL : CFG_VALID;
            CFG_VALID: if (accept && new_ocd == OCD_DFLT) state_d = CFG_CAL;
            CFG_CAL:   if (accept && new_ocd == OCD_EXIT) state_d = CFG_VALID;
            default:   state_d = CFG_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_BLANK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            wr_err    <= 1'b0;
            cfg_err   <= 1'b0;
            rsvd_warn <= 1'b0;
        end else begin
            if (accept) cfg <= cfg_d;
            wr_err    <= load_cmd && !pre_ok;
            cfg_err   <= load_cmd && pre_ok && (al_bad || ocd_bad);
            rsvd_warn <= accept && (ba_hi || addr[11]);               // R8
        end
    end

    assign written     = (state_q != CFG_BLANK);
    assign cal_pending = (state_q == CFG_CAL);

endmodule

// File: rtl/xmr_mrd_timer.sv
module xmr_mrd_timer #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic busy_cmd,
    output logic mrd_viol
);

    localparam int CW = (TMRD < 2) ? 1 : $clog2(TMRD + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TMRD - 1);

    logic [CW-1:0] gap_q;

    // R6 spacing window after an accepted load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= '0;
            mrd_viol <= 1'b0;
        end else begin
            mrd_viol <= (gap_q != '0) && busy_cmd;
            if (accept)            gap_q <= RELOAD;
            else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
        end
    end

endmodule

// File: rtl/xmr_dll_fsm.sv
module xmr_dll_fsm
    import xmr_pkg::*;
#(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    input  logic sre,
    input  logic cke,
    input  logic read_cmd,
    input  logic cfg_dll_on,
    output logic dll_active,
    output logic dll_ready,
    output logic early_rd
);

    localparam int CW = (LOCK_CYC < 4) ? 2 : $clog2(LOCK_CYC);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 2);

    dll_state_e    state_q, state_d;
    logic [CW-1:0] lock_q;

    // R7 R12 transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLL_OFF: begin
                if (sre)         state_d = DLL_SREF;
                else if (on_req) state_d = DLL_LOCKING;
            end
            DLL_LOCKING: begin
                if (sre)                 state_d = DLL_SREF;
                else if (off_req)        state_d = DLL_OFF;
                else if (lock_q == LAST) state_d = DLL_READY;
            end
            DLL_READY: begin
                if (sre)          state_d = DLL_SREF;
                else if (off_req) state_d = DLL_OFF;
            end
            DLL_SREF: begin
                if (cke) state_d = cfg_dll_on ? DLL_LOCKING : DLL_OFF;
            end
            default: state_d = DLL_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DLL_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q   <= '0;
            early_rd <= 1'b0;
        end else begin
            if (state_d == DLL_LOCKING && state_q != DLL_LOCKING) lock_q <= '0;
            else if (state_q == DLL_LOCKING)                      lock_q <= lock_q + 1'b1;
            early_rd <= read_cmd && (state_q == DLL_LOCKING);
        end
    end

    assign dll_active = (state_q == DLL_LOCKING) || (state_q == DLL_READY);
    assign dll_ready  = (state_q == DLL_READY);

endmodule

// File: rtl/ddr2_xmr_tracker.sv
module ddr2_xmr_tracker
    import xmr_pkg::*;
#(
    parameter int TMRD     = 2,
    parameter int LOCK_CYC = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cke,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [2:0]  ba,
    input  logic [12:0] addr,
    input  logic        banks_idle,
    output logic        cfg_written,
    output logic        dll_en_cfg,
    output logic        half_drive,
    output logic [1:0]  odt_sel,
    output logic [2:0]  add_lat,
    output logic [2:0]  ocd_mode,
    output logic        dqsn_off,
    output logic        q_off,
    output logic        cal_pending,
    output logic        dll_active,
    output logic        dll_ready,
    output logic        wr_err,
    output logic        cfg_err,
    output logic        rsvd_warn,
    output logic        mrd_viol,
    output logic        early_rd
);

    logic cke_q;
    cmd_e cmd;
    cfg_t cfg;
    logic accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_q <= 1'b0;
        else        cke_q <= cke;
    end

    xmr_cmd_decode u_dec (
        .cke   (cke),
        .cke_q (cke_q),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba_lo (ba[1:0]),
        .cmd   (cmd)
    );

    xmr_cfg_ctrl u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_cmd    (cmd == CMD_EMR1),
        .pre_ok      (cke_q && banks_idle),
        .addr        (addr),
        .ba_hi       (ba[2]),
        .cfg         (cfg),
        .written     (cfg_written),
        .cal_pending (cal_pending),
        .accept      (accept),
        .wr_err      (wr_err),
        .cfg_err     (cfg_err),
        .rsvd_warn   (rsvd_warn)
    );

    xmr_mrd_timer #(.TMRD(TMRD)) u_mrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .busy_cmd (cmd != CMD_NOP),
        .mrd_viol (mrd_viol)
    );

    xmr_dll_fsm #(.LOCK_CYC(LOCK_CYC)) u_dll (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_req     (accept && !addr[0]),
        .off_req    (accept && addr[0]),
        .sre        (cmd == CMD_SRE),
        .cke        (cke),
        .read_cmd   (cmd == CMD_READ),
        .cfg_dll_on (dll_en_cfg),
        .dll_active (dll_active),
        .dll_ready  (dll_ready),
        .early_rd   (early_rd)
    );

    assign dll_en_cfg = cfg_written && !cfg.dll_off;
    assign half_drive = cfg.half_drive;
    assign odt_sel    = cfg.odt;
    assign add_lat    = cfg.al;
    assign ocd_mode   = cfg.ocd;
    assign dqsn_off   = cfg.dqsn_dis;
    assign q_off      = cfg.q_off;

endmodule

// File: rtl/xmr_tracker_chk.sv
module xmr_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       cfg_written,
    input logic [1:0] odt_sel,
    input logic [2:0] add_lat,
    input logic [2:0] ocd_mode,
    input logic       cal_pending,
    input logic       dll_active,
    input logic       dll_ready,
    input logic       wr_err,
    input logic       cfg_err,
    input logic       rsvd_warn,
    input logic       mrd_viol,
    input logic       early_rd
);

    a_r2_refused_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($stable(add_lat) && $stable(ocd_mode) && $stable(odt_sel) && $stable(cfg_written)));

    a_r3_written_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_written |=> cfg_written);

    a_r5_latency_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_written |-> (add_lat != 3'd7));

    a_r6_spacing_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_viol |-> $past(cke && !cs_n && !(ras_n && cas_n && we_n)));

    a_r7_early_only_while_locking: assert property (@(posedge clk) disable iff (!rst_n)
        early_rd |-> ($past(dll_active) && !$past(dll_ready)));

    a_r8_warn_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_warn |-> cfg_written);

    a_r9_pending_not_exit: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pending |-> (ocd_mode != 3'b000));

    a_r11_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($stable(add_lat) && $stable(ocd_mode)));

    a_r12_sref_stops_dll: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cke) && !cke && !cs_n && !ras_n && !cas_n && we_n) |=> !dll_active);

endmodule

bind ddr2_xmr_tracker xmr_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .cfg_written (cfg_written),
    .odt_sel     (odt_sel),
    .add_lat     (add_lat),
    .ocd_mode    (ocd_mode),
    .cal_pending (cal_pending),
    .dll_active  (dll_active),
    .dll_ready   (dll_ready),
    .wr_err      (wr_err),
    .cfg_err     (cfg_err),
    .rsvd_warn   (rsvd_warn),
    .mrd_viol    (mrd_viol),
    .early_rd    (early_rd)
);

// File: tb/sim_ddr2_xmr_tracker.sv
`timescale 1ns/1ps
module sim_ddr2_xmr_tracker;

    typedef enum {K_NOP, K_DES, K_EMR, K_RD, K_SRE} kind_e;
    typedef struct {
        string       tag;
        logic [20:0] m;
        logic [20:0] e;
    } item_t;

    localparam logic [20:0] M_ALL = 21'h1FFFFF;
    localparam logic [20:0] M_DLL = 21'h000060;
    localparam logic [20:0] M_FL  = 21'h00001F;
    localparam logic [4:0]  F_WERR = 5'b10000;
    localparam logic [4:0]  F_CERR = 5'b01000;
    localparam logic [4:0]  F_WARN = 5'b00100;
    localparam logic [4:0]  F_MRD  = 5'b00010;
    localparam logic [4:0]  F_ERD  = 5'b00001;
    localparam logic [1:0]  D_OFF  = 2'b00;
    localparam logic [1:0]  D_LOCK = 2'b10;
    localparam logic [1:0]  D_RDY  = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        banks_idle = 1'b1;
    logic        cfg_written, dll_en_cfg, half_drive, dqsn_off, q_off, cal_pending;
    logic        dll_active, dll_ready, wr_err, cfg_err, rsvd_warn, mrd_viol, early_rd;
    logic [1:0]  odt_sel;
    logic [2:0]  add_lat, ocd_mode;
    logic [20:0] obs;

    logic cke_v = 1'b1;
    logic idle_v = 1'b1;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    ddr2_xmr_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
        .cfg_written(cfg_written), .dll_en_cfg(dll_en_cfg), .half_drive(half_drive),
        .odt_sel(odt_sel), .add_lat(add_lat), .ocd_mode(ocd_mode), .dqsn_off(dqsn_off),
        .q_off(q_off), .cal_pending(cal_pending), .dll_active(dll_active),
        .dll_ready(dll_ready), .wr_err(wr_err), .cfg_err(cfg_err), .rsvd_warn(rsvd_warn),
        .mrd_viol(mrd_viol), .early_rd(early_rd)
    );

    assign obs = {cfg_written, dll_en_cfg, half_drive, odt_sel, add_lat, ocd_mode,
                  dqsn_off, q_off, cal_pending, dll_active, dll_ready,
                  wr_err, cfg_err, rsvd_warn, mrd_viol, early_rd};

    function automatic logic [13:0] cf(input logic pr, input logic en, input logic hd,
                                       input logic [1:0] od, input logic [2:0] al,
                                       input logic [2:0] oc, input logic dq,
                                       input logic qo, input logic ca);
        return {pr, en, hd, od, al, oc, dq, qo, ca};
    endfunction

    function automatic logic [20:0] ex(input logic [13:0] c, input logic [1:0] d,
                                       input logic [4:0] f);
        return {c, d, f};
    endfunction

    // driver: applies one command per cycle and queues what must follow it
    task automatic step(input kind_e k, input logic [12:0] a, input logic [2:0] b,
                        input string tag, input logic [20:0] m, input logic [20:0] e);
        item_t it;
        @(negedge clk);
        cke = cke_v;
        banks_idle = idle_v;
        addr = a;
        ba = b;
        case (k)
            K_NOP: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            K_DES: {cs_n, ras_n, cas_n, we_n} = 4'b1000;
            K_EMR: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            K_RD:  {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            K_SRE: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
        it.tag = tag;
        it.m = m;
        it.e = e;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(K_NOP, '0, 3'b001, "", '0, '0);
    endtask

    // monitor: compares each queued item just after the edge that sampled its command
    always @(posedge clk) begin
        item_t it;
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            if (it.m != '0) begin
                n_cmp++;
                if ((obs & it.m) !== (it.e & it.m)) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, obs & it.m, it.e & it.m);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cke = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step(K_NOP, '0, 3'b001, "R3 reset state", M_ALL, '0);

        idle_v = 1'b0;
        step(K_EMR, 13'h41E, 3'b001, "R2 banks busy", M_ALL, ex('0, D_OFF, F_WERR));
        idle_v = 1'b1;
        cke_v = 1'b0;
        step(K_NOP, '0, 3'b001, "R2 cke low quiet", M_ALL, '0);
        cke_v = 1'b1;
        step(K_EMR, 13'h41E, 3'b001, "R2 cke just raised", M_ALL, ex('0, D_OFF, F_WERR));

        step(K_EMR, 13'h41E, 3'b001, "R1 R4 R5 accepted load", M_ALL,
             ex(cf(1, 1, 1, 2'b01, 3'd3, 3'b000, 1, 0, 0), D_LOCK, '0));
        step(K_RD, '0, 3'b001, "R6 R7 read right after load", M_DLL | M_FL,
             ex('0, D_LOCK, F_MRD | F_ERD));
        step(K_RD, '0, 3'b001, "R7 read at edge 2", M_DLL | M_FL, ex('0, D_LOCK, F_ERD));
        idle(196);
        step(K_RD, '0, 3'b001, "R7 read at edge 199", M_DLL | M_FL, ex('0, D_RDY, F_ERD));
        step(K_RD, '0, 3'b001, "R7 read at edge 200", M_DLL | M_FL, ex('0, D_RDY, '0));

        step(K_EMR, 13'h1868, 3'b101, "R8 reserved bits warn", M_ALL,
             ex(cf(1, 1, 0, 2'b10, 3'd5, 3'b000, 0, 1, 0), D_RDY, F_WARN));
        step(K_DES, '0, 3'b000, "R6 deselect exempt", M_FL, '0);
        idle(1);

        step(K_EMR, 13'h3D4, 3'b001, "R9 default mode sets pending", M_ALL,
             ex(cf(1, 1, 0, 2'b11, 3'd2, 3'b111, 0, 0, 1), D_RDY, '0));
        idle(2);
        step(K_EMR, 13'h230, 3'b001, "R10 adjust keeps latency", M_ALL,
             ex(cf(1, 1, 0, 2'b00, 3'd2, 3'b100, 0, 0, 1), D_RDY, '0));
        idle(2);
        step(K_EMR, 13'h038, 3'b001, "R11 latency code 7", M_ALL,
             ex(cf(1, 1, 0, 2'b00, 3'd2, 3'b100, 0, 0, 1), D_RDY, F_CERR));
        idle(1);
        step(K_EMR, 13'h180, 3'b001, "R11 undefined mode 011", M_ALL,
             ex(cf(1, 1, 0, 2'b00, 3'd2, 3'b100, 0, 0, 1), D_RDY, F_CERR));
        idle(1);
        step(K_EMR, 13'h000, 3'b001, "R9 exit clears pending", M_ALL,
             ex(cf(1, 1, 0, 2'b00, 3'd0, 3'b000, 0, 0, 0), D_RDY, '0));
        idle(2);

        step(K_EMR, 13'h001, 3'b001, "R12 load turns DLL off", M_ALL,
             ex(cf(1, 0, 0, 2'b00, 3'd0, 3'b000, 0, 0, 0), D_OFF, '0));
        idle(1);
        step(K_RD, '0, 3'b001, "R7 read with DLL off", M_DLL | M_FL, ex('0, D_OFF, '0));
        step(K_EMR, 13'h000, 3'b001, "R12 re-enable starts lock", M_ALL,
             ex(cf(1, 1, 0, 2'b00, 3'd0, 3'b000, 0, 0, 0), D_LOCK, '0));
        idle(150);
        cke_v = 1'b0;
        step(K_SRE, '0, 3'b001, "R12 self refresh entry", M_DLL | M_FL, ex('0, D_OFF, '0));
        idle(3);
        step(K_NOP, '0, 3'b001, "R12 held in self refresh", M_DLL | M_FL, ex('0, D_OFF, '0));
        cke_v = 1'b1;
        step(K_NOP, '0, 3'b001, "R12 self refresh exit", M_DLL | M_FL, ex('0, D_LOCK, '0));
        idle(149);
        step(K_RD, '0, 3'b001, "R12 lock restarted on exit", M_DLL | M_FL,
             ex('0, D_LOCK, F_ERD));

        idle(2);
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule